// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block gathers single-cycle event pulses and alarm level changes from line-monitoring logic into an 8-bit sticky status word. Each status bit has a matching bit in a mask register. A single active-high interrupt line is the OR of every status bit that is set and not masked. A host read of the status word returns its contents and clears every bit in the same cycle.

Two global controls change how events are recorded. The first is a visibility switch. When it is on, masked events are still recorded in the status word, but they never reach the interrupt line. The second is a change-of-state switch for the bits that carry alarm levels. By default those bits flag only when an alarm rises. With the switch on, they flag on every transition of the alarm, in both directions.

A plain register port gives access to the block. It has a 2-bit address and separate read and write strobes, and read data appears one cycle after the strobe.

Top module: `isr_clr_on_read`

## Requirements
- R1: After synchronous reset, the status word is 0x00, the mask is 0xFF (all masked), the control register is 0x00, `irq` is low and `reg_rdata` is 0x00.
- R2: A pulse on `evt_pulse[i]` for a non-alarm bit that is recorded sets status bit i at the next clock edge. The bit stays set until a status read.
- R3: A read strobe at address 0 (status) puts the status word on `reg_rdata` at the next edge and clears every status bit at that edge.
- R4: If an event arrives in the same cycle as a status read, the read returns the value from before the event, and the new event remains set after the read.
- R5: With control bit 0 (visibility) clear, an event on a bit whose mask bit is 1 is not recorded.
- R6: With control bit 0 set, an event on a masked bit is recorded, but that bit never asserts `irq`.
- R7: `irq` is high exactly when at least one status bit is set while its mask bit is 0. It stays high until a status read clears that bit or the mask bit is set.
- R8: Bits selected by parameter ALARM_BITS (default bits 5 and 4) ignore `evt_pulse`. With control bit 1 (change-of-state) clear, such a bit is set only when its `alarm_lvl` input goes from 0 to 1. A level that stays high sets it only once.
- R9: With control bit 1 set, an alarm bit is set on every transition of its `alarm_lvl` input, falling as well as rising.
- R10: Address 1 (mask, 1 = masked) and address 2 (control: bit 0 visibility, bit 1 change-of-state, other bits read 0) read back what was written. Address 3 reads 0x00.
- R11: A write to address 0 has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 reserved |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a status read clears the status word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| evt_pulse | input | 8 | Event pulses for non-alarm bits |
| alarm_lvl | input | 8 | Alarm levels for the bits in ALARM_BITS |
| irq | output | 1 | Active-high interrupt |

## Verification
The functions that can fall in the same cycle are the clearing status read and the recording of a new event. The bench drives an event pulse and a status read on the same negative clock edge. It expects the returned word to hold only the bits recorded earlier, and it expects a second read to return exactly the new event. A sweep over all 256 masks, with visibility both off and on, then checks that recording and interrupt gating agree with a pattern computed arithmetically in the bench.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int STAT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    // bit 1: change-of-state, bit 0: show masked events
    typedef struct packed {
        logic cos_all;
        logic show_masked;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef logic [STAT_W-1:0] stat_t;

    // Alarm transition detector: rising only, or any change.
    function automatic stat_t alarm_edges(stat_t cur, stat_t prev, logic both);
        return both ? (cur ^ prev) : (cur & ~prev);
    endfunction

    // Recording gate: unmasked bits always, masked bits only when shown.
    function automatic stat_t record_gate(stat_t ev, stat_t mask, logic show);
        return ev & (~mask | {STAT_W{show}});
    endfunction

    function automatic stat_t ctrl_to_word(ctrl_t c);
        stat_t w;
        w = '0;
        w[CTRL_W-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/isr_alarm_edge.sv
module isr_alarm_edge
    import isr_pkg::*;
#(
    parameter stat_t ALARM_BITS = 8'h30
) (
    input  logic  clk,
    input  logic  rst,
    input  stat_t lvl,
    input  stat_t pulse_in,
    input  logic  both_edges,
    output stat_t ev_out
);

    stat_t lvl_q;
    stat_t edges;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl & ALARM_BITS;
    end

    always_comb edges = alarm_edges(lvl & ALARM_BITS, lvl_q, both_edges);

    for (genvar i = 0; i < STAT_W; i++) begin : g_src
        if (ALARM_BITS[i]) begin : g_alarm
            assign ev_out[i] = edges[i];
        end else begin : g_pulse
            assign ev_out[i] = pulse_in[i];
        end
    end

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !both_edges |-> ((ev_out & ALARM_BITS & ~lvl) == '0)); // R8

endmodule

// File: rtl/isr_cfg_regs.sv
module isr_cfg_regs
    import isr_pkg::*;
#(
    parameter stat_t RST_MASK = 8'hFF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  reg_sel_e sel,
    input  stat_t    wdata,
    output stat_t    mask_q,
    output ctrl_t    ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= RST_MASK;
            ctrl_q <= '0;
        end else if (wr) begin
            if (sel == SEL_MASK) mask_q <= wdata;
            if (sel == SEL_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_MASK) |=> $stable(mask_q)); // R10

endmodule

// File: rtl/isr_status_core.sv
module isr_status_core
    import isr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t ev,
    input  stat_t mask,
    input  logic  show_masked,
    input  logic  clr,
    output stat_t status_q,
    output logic  irq
);

    stat_t rec;

    always_comb rec = record_gate(ev, mask, show_masked);

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (clr ? '0 : status_q) | rec;
    end

    always_comb irq = |(status_q & ~mask);

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && ev == '0) |=> (status_q == '0)); // R3

    AST_HIDDEN_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (!show_masked && !clr) |=> ((status_q & ~$past(status_q) & $past(mask)) == '0)); // R5

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> (irq || (mask != $past(mask)))); // R7

endmodule

// File: rtl/isr_clr_on_read.sv
module isr_clr_on_read
    import isr_pkg::*;
#(
    parameter stat_t ALARM_BITS = 8'h30,
    parameter stat_t RST_MASK   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_pulse,
    input  logic [STAT_W-1:0] alarm_lvl,
    output logic              irq
);

    reg_sel_e sel;
    stat_t    mask_q;
    ctrl_t    ctrl_q;
    stat_t    ev;
    stat_t    status_q;
    stat_t    rd_mux;
    logic     clr;

    always_comb sel = reg_sel_e'(reg_addr);
    always_comb clr = reg_rd && (sel == SEL_STATUS);

    isr_cfg_regs #(.RST_MASK(RST_MASK)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .sel    (sel),
        .wdata  (reg_wdata),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q)
    );

    isr_alarm_edge #(.ALARM_BITS(ALARM_BITS)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .lvl        (alarm_lvl),
        .pulse_in   (evt_pulse),
        .both_edges (ctrl_q.cos_all),
        .ev_out     (ev)
    );

    isr_status_core u_core (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .mask        (mask_q),
        .show_masked (ctrl_q.show_masked),
        .clr         (clr),
        .status_q    (status_q),
        .irq         (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_q;
            SEL_MASK:   rd_mux = mask_q;
            SEL_CTRL:   rd_mux = ctrl_to_word(ctrl_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status_q == '0 && !irq && reg_rdata == '0)); // R1

    AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
        clr |=> (reg_rdata == $past(status_q))); // R4

endmodule

// File: tb/test_isr_clr_on_read.sv
module test_isr_clr_on_read;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] evt_pulse = '0;
    logic [7:0] alarm_lvl = '0;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [7:0] ALM = 8'h30;

    always #5 clk = ~clk;

    isr_clr_on_read i_isr_clr_on_read (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .alarm_lvl(alarm_lvl), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(logic [7:0] p);
        @(negedge clk);
        evt_pulse = p;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] p;
        logic [7:0] ex;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 rdata", reg_rdata, 8'h00);
        rd(2'd0, d); check("R1 status", d, 8'h00);
        rd(2'd1, d); check("R1 mask", d, 8'hFF);
        rd(2'd2, d); check("R1 ctrl", d, 8'h00);
        rd(2'd3, d); check("R10 reserved", d, 8'h00);

        // R11 write to status ignored
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        check("R11 irq", {7'd0, irq}, 8'h00);
        rd(2'd0, d); check("R11 status", d, 8'h00);

        // R10 control readback
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R10 ctrl", d, 8'h03);
        wr(2'd2, 8'h00);

        // Sweep over every mask, visibility off and on: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < 2; v++) begin
            for (int m = 0; m < 256; m++) begin
                p  = 8'((m * 29 + 7 + v * 101) ^ (m >> 1));
                ex = p & ~ALM & (~8'(m) | {8{v[0]}});
                wr(2'd1, 8'(m));
                wr(2'd2, {7'd0, v[0]});
                rd(2'd1, d); check("R10 mask", d, 8'(m));
                pulse(p);
                check("R7 R6 irq", {7'd0, irq}, {7'd0, |(ex & ~8'(m))});
                rd(2'd0, d); check("R2 R5 R6 R8 status", d, ex);
                check("R3 irq after read", {7'd0, irq}, 8'h00);
                rd(2'd0, d); check("R3 cleared", d, 8'h00);
            end
        end

        // R4 event together with clearing read
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        pulse(8'h81);
        @(negedge clk);
        evt_pulse = 8'h06; reg_addr = 2'd0; reg_rd = 1'b1;
        @(negedge clk);
        evt_pulse = '0; reg_rd = 1'b0;
        check("R4 old value", reg_rdata, 8'h81);
        check("R4 irq held", {7'd0, irq}, 8'h01);
        rd(2'd0, d); check("R4 new kept", d, 8'h06);

        // R7 irq held until read, dropped by masking
        pulse(8'h40);
        repeat (5) @(negedge clk);
        check("R7 hold", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h40);
        check("R7 masked", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h00);
        check("R7 unmasked", {7'd0, irq}, 8'h01);
        rd(2'd0, d); check("R7 status", d, 8'h40);

        // R8 / R9 alarm levels
        for (int c = 0; c < 2; c++) begin
            wr(2'd2, {6'd0, c[0], 1'b0});
            rd(2'd0, d);
            @(negedge clk); alarm_lvl = 8'h20;
            @(negedge clk);
            check("R8 R9 rise irq", {7'd0, irq}, 8'h01);
            rd(2'd0, d); check("R8 R9 rise", d, 8'h20);
            repeat (3) @(negedge clk);
            rd(2'd0, d); check("R8 level held once", d, 8'h00);
            @(negedge clk); alarm_lvl = 8'h00;
            @(negedge clk);
            rd(2'd0, d);
            check(c ? "R9 fall flags" : "R8 fall ignored", d, c ? 8'h20 : 8'h00);
            @(negedge clk); alarm_lvl = 8'h10;
            @(negedge clk); alarm_lvl = 8'h00;
            @(negedge clk);
            rd(2'd0, d);
            check(c ? "R9 both edges" : "R8 rise only", d, 8'h10);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule